// File: doc/BRIEF.md
# Dual-Bank Byte Buffer with Role Swap

The block holds two byte FIFO banks of equal, parameterised depth. At any time one bank faces the processor port and the other faces the bus-engine port. A one-bit bank select decides which is which. A swap command toggles that select, so each bank changes sides in one cycle. This lets the processor fill or drain one bank while the bus engine streams the other bank. A long transfer is cut into pieces no larger than one bank, and the next piece is armed on the bus side while the processor still works on the previous one.

Both ports have push and pop strobes. Read data is show-ahead: each port presents the head byte of its bank, and a pop moves to the next byte. The processor side reports empty and full for its bank and an empty flag for the other bank. Processor accesses that cannot be served (a push to a full bank, a pop from an empty bank) are dropped and leave sticky error flags. A swap does not touch the pointers, so bytes left in a bank remain there after the swap.

Top module: `dual_bank_fifo`

## Requirements
- R1: After the asynchronous active-low reset, the select output is 0, both banks are empty, cpu_full_o is 0 and both sticky flags are 0.
- R2: A cycle with swap_i high toggles sel_o at the next clock edge. In any other cycle sel_o keeps its value. When sel_o is 0, bank 0 faces the processor; when sel_o is 1, bank 1 faces the processor.
- R3: Bytes pushed on the processor port come back on that port in the order they were pushed. cpu_rdata_o shows the head byte while the bank is not empty.
- R4: The bus-side bank behaves as an independent FIFO through bus_push_i, bus_pop_i and bus_rdata_o, with show-ahead head data.
- R5: cpu_empty_o is 1 exactly when the processor-side bank holds 0 bytes. cpu_full_o is 1 exactly when it holds DEPTH bytes.
- R6: alt_empty_o is 1 exactly when the bus-side bank holds 0 bytes.
- R7: A processor push to a full bank stores nothing and sets ovf_o. ovf_o stays 1 until reset.
- R8: A processor pop from an empty bank changes nothing and sets udf_o. udf_o stays 1 until reset.
- R9: A push or pop in the same cycle as a swap acts on the bank that was on that side before the swap.
- R10: A swap does not move or drop data. Bytes left in a bank are still readable, in order, from whichever side the bank moves to.
- R11: A bus-side push to a full bank or a bus-side pop from an empty bank is dropped, and the error flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swap_i | input | 1 | Exchange the two banks between sides |
| cpu_push_i | input | 1 | Processor write strobe |
| cpu_wdata_i | input | DW | Processor write byte |
| cpu_pop_i | input | 1 | Processor read strobe |
| cpu_rdata_o | output | DW | Head byte of the processor-side bank |
| bus_push_i | input | 1 | Bus-engine write strobe |
| bus_wdata_i | input | DW | Bus-engine write byte |
| bus_pop_i | input | 1 | Bus-engine read strobe |
| bus_rdata_o | output | DW | Head byte of the bus-side bank |
| sel_o | output | 1 | Index of the bank facing the processor |
| cpu_empty_o | output | 1 | Processor-side bank is empty |
| cpu_full_o | output | 1 | Processor-side bank is full |
| alt_empty_o | output | 1 | Bus-side bank is empty |
| ovf_o | output | 1 | Sticky: processor pushed to a full bank |
| udf_o | output | 1 | Sticky: processor popped an empty bank |

## Verification
The hardest case to reach is a swap in the same cycle as accesses on both sides, with partly filled banks and pointers that have already wrapped. In that case a wrong bank choice or a reset pointer still gives plausible data. The stimulus first drives both banks to full and to empty with directed sequences. It then runs a long random phase with frequent swaps mixed into simultaneous push and pop traffic on both ports. A model of two queues predicts every head byte and flag.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } ppf_req_t;

  typedef struct packed {
    logic empty;
    logic full;
  } ppf_stat_t;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/ppf_bank.sv
module ppf_bank #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ppf_pkg::ppf_req_t   req_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output ppf_pkg::ppf_stat_t  stat_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign stat_o.empty = (cnt_q == '0);
  assign stat_o.full  = (cnt_q == FULL_CNT);
  assign do_push = req_i.push && !stat_o.full;
  assign do_pop  = req_i.pop && !stat_o.empty;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ppf_router.sv
module ppf_router #(
  parameter int unsigned DW = 8
) (
  input  logic                sel_i,
  input  ppf_pkg::ppf_req_t   cpu_req_i,
  input  logic [DW-1:0]       cpu_wdata_i,
  input  ppf_pkg::ppf_req_t   bus_req_i,
  input  logic [DW-1:0]       bus_wdata_i,
  output ppf_pkg::ppf_req_t   bank_req_o   [ppf_pkg::NUM_BANKS],
  output logic [DW-1:0]       bank_wdata_o [ppf_pkg::NUM_BANKS],
  input  logic [DW-1:0]       bank_rdata_i [ppf_pkg::NUM_BANKS],
  input  ppf_pkg::ppf_stat_t  bank_stat_i  [ppf_pkg::NUM_BANKS],
  output logic [DW-1:0]       cpu_rdata_o,
  output logic [DW-1:0]       bus_rdata_o,
  output ppf_pkg::ppf_stat_t  cpu_stat_o,
  output ppf_pkg::ppf_stat_t  bus_stat_o
);
  for (genvar b = 0; b < ppf_pkg::NUM_BANKS; b++) begin : g_route
    localparam logic IDX = 1'(b);
    assign bank_req_o[b]   = (sel_i == IDX) ? cpu_req_i   : bus_req_i;
    assign bank_wdata_o[b] = (sel_i == IDX) ? cpu_wdata_i : bus_wdata_i;
  end

  assign cpu_rdata_o = bank_rdata_i[sel_i];
  assign bus_rdata_o = bank_rdata_i[~sel_i];
  assign cpu_stat_o  = bank_stat_i[sel_i];
  assign bus_stat_o  = bank_stat_i[~sel_i];
endmodule

// File: rtl/dual_bank_fifo.sv
module dual_bank_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_i,
  input  logic          cpu_push_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_pop_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          bus_push_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic          bus_pop_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          sel_o,
  output logic          cpu_empty_o,
  output logic          cpu_full_o,
  output logic          alt_empty_o,
  output logic          ovf_o,
  output logic          udf_o
);
  import ppf_pkg::*;

  logic      sel_q, ovf_q, udf_q;
  ppf_req_t  cpu_req, bus_req;
  ppf_req_t  bank_req   [NUM_BANKS];
  logic [DW-1:0] bank_wdata [NUM_BANKS];
  logic [DW-1:0] bank_rdata [NUM_BANKS];
  ppf_stat_t bank_stat  [NUM_BANKS];
  ppf_stat_t cpu_stat, bus_stat;

  assign cpu_req = '{push: cpu_push_i, pop: cpu_pop_i};
  assign bus_req = '{push: bus_push_i, pop: bus_pop_i};

  ppf_router #(.DW(DW)) u_router (
    .sel_i        (sel_q),
    .cpu_req_i    (cpu_req),
    .cpu_wdata_i  (cpu_wdata_i),
    .bus_req_i    (bus_req),
    .bus_wdata_i  (bus_wdata_i),
    .bank_req_o   (bank_req),
    .bank_wdata_o (bank_wdata),
    .bank_rdata_i (bank_rdata),
    .bank_stat_i  (bank_stat),
    .cpu_rdata_o  (cpu_rdata_o),
    .bus_rdata_o  (bus_rdata_o),
    .cpu_stat_o   (cpu_stat),
    .bus_stat_o   (bus_stat)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ppf_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (bank_req[b]),
      .wdata_i (bank_wdata[b]),
      .rdata_o (bank_rdata[b]),
      .stat_o  (bank_stat[b])
    );
  end

  // select flips after the access of the same cycle has used the old value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (swap_i) sel_q <= ~sel_q;
      if (cpu_push_i && cpu_stat.full)  ovf_q <= 1'b1;
      if (cpu_pop_i  && cpu_stat.empty) udf_q <= 1'b1;
    end
  end

  assign sel_o       = sel_q;
  assign cpu_empty_o = cpu_stat.empty;
  assign cpu_full_o  = cpu_stat.full;
  assign alt_empty_o = bus_stat.empty;
  assign ovf_o       = ovf_q;
  assign udf_o       = udf_q;
endmodule

// File: rtl/dual_bank_fifo_chk.sv
module dual_bank_fifo_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic swap_i,
  input logic cpu_push_i,
  input logic cpu_pop_i,
  input logic bus_push_i,
  input logic bus_pop_i,
  input logic sel_o,
  input logic cpu_empty_o,
  input logic cpu_full_o,
  input logic alt_empty_o,
  input logic ovf_o,
  input logic udf_o
);
  AST_SWAP_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> sel_o != $past(sel_o)); // R2
  AST_SEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i |=> $stable(sel_o)); // R2
  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_empty_o && cpu_full_o)); // R5
  AST_OVF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_push_i && cpu_full_o |=> ovf_o); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R7
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_push_i && cpu_full_o && !cpu_pop_i && !swap_i |=> cpu_full_o); // R7
  AST_UDF_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_pop_i && cpu_empty_o |=> udf_o); // R8
  AST_UDF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |=> udf_o); // R8
  AST_EMPTY_POP_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_pop_i && cpu_empty_o && !cpu_push_i && !swap_i |=> cpu_empty_o); // R8
  AST_SWAP_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i && !cpu_push_i && !cpu_pop_i && !bus_push_i && !bus_pop_i
    |=> (alt_empty_o == $past(cpu_empty_o)) && (cpu_empty_o == $past(alt_empty_o))); // R10
endmodule

bind dual_bank_fifo dual_bank_fifo_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .swap_i      (swap_i),
  .cpu_push_i  (cpu_push_i),
  .cpu_pop_i   (cpu_pop_i),
  .bus_push_i  (bus_push_i),
  .bus_pop_i   (bus_pop_i),
  .sel_o       (sel_o),
  .cpu_empty_o (cpu_empty_o),
  .cpu_full_o  (cpu_full_o),
  .alt_empty_o (alt_empty_o),
  .ovf_o       (ovf_o),
  .udf_o       (udf_o)
);

// File: tb/sim_dual_bank_fifo.sv
module sim_dual_bank_fifo;
  localparam int DEPTH = 8;
  localparam int DW    = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, swap, cpu_push, cpu_pop, bus_push, bus_pop;
  logic [DW-1:0] cpu_wdata, bus_wdata, cpu_rdata, bus_rdata;
  logic sel, cpu_empty, cpu_full, alt_empty, ovf, udf;

  dual_bank_fifo #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .swap_i(swap),
    .cpu_push_i(cpu_push), .cpu_wdata_i(cpu_wdata), .cpu_pop_i(cpu_pop), .cpu_rdata_o(cpu_rdata),
    .bus_push_i(bus_push), .bus_wdata_i(bus_wdata), .bus_pop_i(bus_pop), .bus_rdata_o(bus_rdata),
    .sel_o(sel), .cpu_empty_o(cpu_empty), .cpu_full_o(cpu_full), .alt_empty_o(alt_empty),
    .ovf_o(ovf), .udf_o(udf)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] q0[$], q1[$];
  logic m_sel = 1'b0, m_ovf = 1'b0, m_udf = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int qsize(logic b);
    return b ? q1.size() : q0.size();
  endfunction

  function automatic int qfront(logic b);
    return b ? int'(q1[0]) : int'(q0[0]);
  endfunction

  task automatic qpush(logic b, logic [DW-1:0] v);
    if (b) q1.push_back(v); else q0.push_back(v);
  endtask

  task automatic qpop(logic b);
    if (b) void'(q1.pop_front()); else void'(q0.pop_front());
  endtask

  // one cycle: monitor compares last edge's result, driver applies stimulus
  task automatic cyc(bit fl, bit cw, logic [DW-1:0] cd, bit cr,
                     bit bw, logic [DW-1:0] bd, bit br, string tag);
    int cs, bs;
    @(negedge clk);
    chk("R5", "cpu_empty", cpu_empty, qsize(m_sel) == 0);
    chk("R5", "cpu_full", cpu_full, qsize(m_sel) == DEPTH);
    chk("R6", "alt_empty", alt_empty, qsize(!m_sel) == 0);
    chk("R2", "sel", sel, m_sel);
    chk("R7", "ovf", ovf, m_ovf);
    chk("R8", "udf", udf, m_udf);
    cs = qsize(m_sel);
    bs = qsize(!m_sel);
    if (cr && cs > 0) chk(tag, "cpu_rdata", cpu_rdata, qfront(m_sel));
    if (br && bs > 0) chk(tag, "bus_rdata", bus_rdata, qfront(!m_sel));
    swap = fl; cpu_push = cw; cpu_wdata = cd; cpu_pop = cr;
    bus_push = bw; bus_wdata = bd; bus_pop = br;
    if (cr && cs > 0) qpop(m_sel);
    if (cw && cs < DEPTH) qpush(m_sel, cd);
    if (br && bs > 0) qpop(!m_sel);
    if (bw && bs < DEPTH) qpush(!m_sel, bd);
    if (cw && cs == DEPTH) m_ovf = 1'b1;
    if (cr && cs == 0) m_udf = 1'b1;
    if (fl) m_sel = ~m_sel;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; swap = 0; cpu_push = 0; cpu_pop = 0; bus_push = 0; bus_pop = 0;
    cpu_wdata = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "sel", sel, 0);
    chk("R1", "cpu_empty", cpu_empty, 1);
    chk("R1", "alt_empty", alt_empty, 1);
    chk("R1", "cpu_full", cpu_full, 0);
    chk("R1", "flags", {ovf, udf}, 0);
    // fill CPU bank, then overflow
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 8'(8'h10 + i), 0, 0, 0, 0, "R3");
    cyc(0, 1, 8'hEE, 0, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, 0, 0, 0, "R2");
    // bus drains the filled bank while CPU fills the other
    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 8'(8'hA0 + i), 0, 0, 0, 1, "R4");
    cyc(0, 0, 0, 0, 0, 0, 1, "R11");
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 0, 1, 8'(8'h30 + i), 0, "R11");
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 0, 0, 0, "R3");
    cyc(0, 0, 0, 1, 0, 0, 0, "R8");
    // swap in the same cycle as a CPU push
    cyc(1, 1, 8'h55, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 1, 0, 0, 1, "R9");
    cyc(1, 0, 0, 0, 0, 0, 0, "R10");
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 0, 0, 0, "R10");
    // random traffic with frequent swaps
    for (int i = 0; i < 2000; i++)
      cyc(($urandom % 6) == 0, $urandom % 2, 8'($urandom), ($urandom % 3) == 0,
          $urandom % 2, 8'($urandom), ($urandom % 3) == 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, "R3");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule